// File: doc/BRIEF.md
# Residue-3 Shadow-Checked Arithmetic Datapath

This block is a small register-file datapath that computes add, subtract and multiply results from two operand ports and stores them in one of several result registers. Next to every main register sits a 2-bit shadow that holds the expected value of that register modulo 3. The shadow is computed by cheap modulo-3 units from residues of the operands. These units run one clock behind the main path, so the main clock period is unaffected.

A single shared mod-3 reducer is time-multiplexed across the result registers. At scheduled checkpoint cycles it reduces one main register, visiting them in round-robin order, and compares the result with that register's shadow. Any disagreement raises a sticky error and marks which register failed. A result can be read back through a registered read port. A fault-injection port can flip a chosen bit of a main register or of a shadow, which lets a test show that a corruption is caught at the victim's next checkpoint.

Top module: `res3_guard_dp`

## Requirements
- R1: After synchronous reset every result register and shadow is zero, and `err_flag`, `err_src`, `chk_done`, `chk_idx` and `rd_data` read zero.
- R2: With `op_valid` high, `op_code` 2'b00 stores `op_a + op_b`, 2'b01 stores `op_a - op_b` modulo 2^RES_W, and 2'b10 stores `op_a * op_b`. The operands are zero-extended to RES_W bits, and the result is written into register `op_dst` at the clock edge that samples the request.
- R3: `op_code` 2'b11 writes nothing: the target register keeps its value and no error follows.
- R4: `rd_data` presents the register selected by `rd_sel` one clock after the selection is sampled.
- R5: The shadow of a written register is updated one clock after the main write. It equals the result modulo 3, coded 0, 1 or 2, and includes the 2^RES_W wrap of a borrowing subtraction. Consistent contents never raise an error.
- R6: A checkpoint occurs every CHK_PERIOD cycles. It checks the registers in ascending order from register 0, wrapping after NREG-1. Each check produces a one-cycle `chk_done` pulse with the checked index on `chk_idx`.
- R7: When a register's checkpoint falls while its shadow update is still pending, that check is postponed by one cycle. The next checkpoint spacing then becomes CHK_PERIOD+1, and no false error is raised.
- R8: A single flipped bit in a main register is reported at that register's next checkpoint, which comes NREG*CHK_PERIOD cycles after its previous one. Checks of other registers do not report it. `err_src` bit k corresponds to register k.
- R9: A shadow holding the illegal code 3 is reported as an error at its register's checkpoint.
- R10: `err_flag` and `err_src` stay set until `err_clr` is sampled high, which clears them at that edge. A detection in the same cycle as a clear takes precedence.
- R11: With `inj_en` high, bit `inj_bit` of main register `inj_reg` is inverted. When `inj_shadow` is also high, shadow bit `inj_bit[0]` of that register is inverted instead, and the main value is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 00 add, 01 subtract, 10 multiply, 11 no operation |
| op_dst | input | $clog2(NREG) | Destination register |
| op_a | input | OP_W | First operand |
| op_b | input | OP_W | Second operand |
| rd_sel | input | $clog2(NREG) | Read-back register select |
| rd_data | output | RES_W | Registered read-back value |
| err_clr | input | 1 | Synchronous clear of the error state |
| inj_en | input | 1 | Fault injection strobe |
| inj_shadow | input | 1 | Inject into the shadow instead of the main register |
| inj_reg | input | $clog2(NREG) | Injection target register |
| inj_bit | input | $clog2(RES_W) | Bit to invert |
| err_flag | output | 1 | Sticky error indication |
| err_src | output | NREG | Sticky per-register failure mask |
| chk_done | output | 1 | A checkpoint completed in the previous cycle |
| chk_idx | output | $clog2(NREG) | Register index of that checkpoint |

## Verification
The bench builds the block with 8-bit operands, an odd result width of 17, four registers and a checkpoint every 3 cycles. The odd width makes the borrow correction of a subtraction 2 rather than 1. It also leaves some `inj_bit` codes beyond the top bit. The short period keeps a full round of checks to 12 cycles. That makes it practical to measure exact detection latency, the one-cycle postponement when a write lands just before a checkpoint, and the precedence of detection over clear.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_NOP = 2'b11
  } op_e;

  // sum of two legal residues, folded back into 0..2
  function automatic logic [1:0] m3_add(input logic [1:0] x, input logic [1:0] y);
    logic [2:0] s;
    s = {1'b0, x} + {1'b0, y};
    return (s >= 3'd3) ? 2'(s - 3'd3) : s[1:0];
  endfunction

  function automatic logic [1:0] m3_neg(input logic [1:0] x);
    case (x)
      2'd1:    return 2'd2;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] m3_mul(input logic [1:0] x, input logic [1:0] y);
    logic [3:0] p;
    p = {2'b00, x} * {2'b00, y};
    return (p >= 4'd3) ? 2'(p - 4'd3) : p[1:0];
  endfunction
endpackage

// File: rtl/rg_mod3_reduce.sv
module rg_mod3_reduce #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  output logic [1:0]   res
);
  import rg_pkg::*;

  localparam int ND = (W + 1) / 2;          // base-4 digits
  localparam int PW = ND * 2;
  localparam int LV = 1 << $clog2(ND);      // leaves of the adder tree

  logic [PW-1:0] padded;
  logic [1:0]    nd [2*LV-1];

  assign padded = PW'(val);

  // 4 = 1 (mod 3): every base-4 digit carries weight 1
  always_comb begin
    for (int i = 0; i < LV; i++) begin
      if (i < ND) nd[LV-1+i] = (padded[2*i +: 2] == 2'd3) ? 2'd0 : padded[2*i +: 2];
      else        nd[LV-1+i] = 2'd0;
    end
    for (int i = LV - 2; i >= 0; i--) begin
      nd[i] = m3_add(nd[2*i+1], nd[2*i+2]);
    end
  end

  assign res = nd[0];
endmodule

// File: rtl/rg_shadow_alu.sv
module rg_shadow_alu #(
  parameter int RES_W = 16
) (
  input  rg_pkg::op_e op,
  input  logic [1:0]  ra,
  input  logic [1:0]  rb,
  input  logic        borrow,
  output logic [1:0]  res
);
  import rg_pkg::*;

  // 2^RES_W mod 3: 1 for even widths, 2 for odd widths
  localparam logic [1:0] WRAP = (RES_W % 2 == 1) ? 2'd2 : 2'd1;

  logic [1:0] diff;
  assign diff = m3_add(ra, m3_neg(rb));

  always_comb begin
    case (op)
      OP_ADD:  res = m3_add(ra, rb);
      OP_SUB:  res = borrow ? m3_add(diff, WRAP) : diff;
      OP_MUL:  res = m3_mul(ra, rb);
      default: res = 2'd0;
    endcase
  end
endmodule

// File: rtl/rg_check_sched.sv
module rg_check_sched #(
  parameter int NREG       = 4,
  parameter int CHK_PERIOD = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hold,
  output logic                    fire,
  output logic [$clog2(NREG)-1:0] ptr
);
  localparam int IDX_W = $clog2(NREG);
  localparam int CW    = (CHK_PERIOD > 1) ? $clog2(CHK_PERIOD) : 1;

  logic [CW-1:0] cnt;
  logic          due;

  assign due  = (cnt == CW'(CHK_PERIOD - 1));
  assign fire = due && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ptr <= '0;
    end else if (fire) begin
      cnt <= '0;
      ptr <= (ptr == IDX_W'(NREG - 1)) ? '0 : ptr + 1'b1;
    end else if (!due) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: the pointer moves on after every check
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> ptr != $past(ptr));

  generate
    if (CHK_PERIOD > 1) begin : g_gap
      p_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);
    end
  endgenerate
endmodule

// File: rtl/res3_guard_dp.sv
module res3_guard_dp #(
  parameter int OP_W       = 8,
  parameter int RES_W      = 16,
  parameter int NREG       = 4,
  parameter int CHK_PERIOD = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     op_valid,
  input  logic [1:0]               op_code,
  input  logic [$clog2(NREG)-1:0]  op_dst,
  input  logic [OP_W-1:0]          op_a,
  input  logic [OP_W-1:0]          op_b,
  input  logic [$clog2(NREG)-1:0]  rd_sel,
  output logic [RES_W-1:0]         rd_data,
  input  logic                     err_clr,
  input  logic                     inj_en,
  input  logic                     inj_shadow,
  input  logic [$clog2(NREG)-1:0]  inj_reg,
  input  logic [$clog2(RES_W)-1:0] inj_bit,
  output logic                     err_flag,
  output logic [NREG-1:0]          err_src,
  output logic                     chk_done,
  output logic [$clog2(NREG)-1:0]  chk_idx
);
  import rg_pkg::*;

  localparam int IDX_W = $clog2(NREG);

  op_e             op;
  logic            op_wr;
  logic [RES_W-1:0] ext_a, ext_b, main_res;
  logic [1:0]      in_ra, in_rb;

  logic [RES_W-1:0] main_q [NREG];
  logic [1:0]       sh_q   [NREG];

  // one-cycle deferred shadow stage
  logic             pend_v;
  logic [IDX_W-1:0] pend_dst;
  logic [1:0]       pend_ra, pend_rb;
  op_e              pend_op;
  logic             pend_borrow;
  logic [1:0]       sh_res;

  logic             ck_fire, ck_hold, ck_mism;
  logic [IDX_W-1:0] ck_ptr;
  logic [1:0]       ck_red;
  logic [RES_W-1:0] main_flip;
  logic [1:0]       sh_flip;

  assign op    = op_e'(op_code);
  assign op_wr = op_valid && (op != OP_NOP);
  assign ext_a = RES_W'(op_a);
  assign ext_b = RES_W'(op_b);

  always_comb begin
    case (op)
      OP_SUB:  main_res = ext_a - ext_b;
      OP_MUL:  main_res = ext_a * ext_b;
      default: main_res = ext_a + ext_b;
    endcase
  end

  rg_mod3_reduce #(.W(OP_W)) u_red_a (.val(op_a), .res(in_ra));
  rg_mod3_reduce #(.W(OP_W)) u_red_b (.val(op_b), .res(in_rb));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v      <= 1'b0;
      pend_dst    <= '0;
      pend_ra     <= '0;
      pend_rb     <= '0;
      pend_op     <= OP_NOP;
      pend_borrow <= 1'b0;
    end else begin
      pend_v      <= op_wr;
      pend_dst    <= op_dst;
      pend_ra     <= in_ra;
      pend_rb     <= in_rb;
      pend_op     <= op;
      pend_borrow <= (op_a < op_b);
    end
  end

  rg_shadow_alu #(.RES_W(RES_W)) u_sh_alu (
    .op(pend_op), .ra(pend_ra), .rb(pend_rb), .borrow(pend_borrow), .res(sh_res)
  );

  assign main_flip = RES_W'(1) << inj_bit;
  assign sh_flip   = 2'(1) << inj_bit[0];

  // main registers: an operation write overrides an injection to the same slot
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) main_q[i] <= '0;
    end else begin
      if (inj_en && !inj_shadow) main_q[inj_reg] <= main_q[inj_reg] ^ main_flip;
      if (op_wr) main_q[op_dst] <= main_res;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) sh_q[i] <= '0;
    end else begin
      if (inj_en && inj_shadow) sh_q[inj_reg] <= sh_q[inj_reg] ^ sh_flip;
      if (pend_v) sh_q[pend_dst] <= sh_res;
    end
  end

  // checkpoint: shared reducer on the scheduled register
  assign ck_hold = pend_v && (pend_dst == ck_ptr);

  rg_check_sched #(.NREG(NREG), .CHK_PERIOD(CHK_PERIOD)) u_sched (
    .clk(clk), .rst(rst), .hold(ck_hold), .fire(ck_fire), .ptr(ck_ptr)
  );

  rg_mod3_reduce #(.W(RES_W)) u_red_chk (.val(main_q[ck_ptr]), .res(ck_red));

  assign ck_mism = (ck_red != sh_q[ck_ptr]) || (sh_q[ck_ptr] == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      err_src  <= '0;
      chk_done <= 1'b0;
      chk_idx  <= '0;
      rd_data  <= '0;
    end else begin
      chk_done <= ck_fire;
      chk_idx  <= ck_fire ? ck_ptr : chk_idx;
      rd_data  <= main_q[rd_sel];
      if (err_clr) begin
        err_flag <= 1'b0;
        err_src  <= '0;
      end
      if (ck_fire && ck_mism) begin
        err_flag        <= 1'b1;
        err_src[ck_ptr] <= 1'b1;
      end
    end
  end

  // R5: the deferred shadow unit only produces legal codes
  p_shadow_code_r5: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> sh_res != 2'd3);
  // R9: the shared reducer never yields the illegal code
  p_red_legal_r9: assert property (@(posedge clk) disable iff (rst)
    ck_fire |-> ck_red != 2'd3);
  // R7: no check is taken on a register whose shadow is still in flight
  p_no_stale_r7: assert property (@(posedge clk) disable iff (rst)
    ck_fire |-> !(pend_v && pend_dst == ck_ptr));
  // R8: a mismatch at a checkpoint is reported on the next cycle
  p_detect_r8: assert property (@(posedge clk) disable iff (rst)
    ck_fire && ck_mism |=> err_flag && chk_done);
  // R10: sticky until cleared
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_flag && !err_clr |=> err_flag);
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    err_clr && !(ck_fire && ck_mism) |=> !err_flag && err_src == '0);
endmodule

// File: tb/res3_guard_dp_tb_top.sv
`timescale 1ns/1ps
module res3_guard_dp_tb_top;
  localparam int OP_W  = 8;
  localparam int RES_W = 17;
  localparam int NREG  = 4;
  localparam int PER   = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             op_valid = 1'b0;
  logic [1:0]       op_code = 2'b00;
  logic [1:0]       op_dst = '0;
  logic [OP_W-1:0]  op_a = '0, op_b = '0;
  logic [1:0]       rd_sel = '0;
  logic [RES_W-1:0] rd_data;
  logic             err_clr = 1'b0;
  logic             inj_en = 1'b0, inj_shadow = 1'b0;
  logic [1:0]       inj_reg = '0;
  logic [4:0]       inj_bit = '0;
  logic             err_flag;
  logic [NREG-1:0]  err_src;
  logic             chk_done;
  logic [1:0]       chk_idx;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  res3_guard_dp #(.OP_W(OP_W), .RES_W(RES_W), .NREG(NREG), .CHK_PERIOD(PER)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_dst(op_dst),
    .op_a(op_a), .op_b(op_b), .rd_sel(rd_sel), .rd_data(rd_data), .err_clr(err_clr),
    .inj_en(inj_en), .inj_shadow(inj_shadow), .inj_reg(inj_reg), .inj_bit(inj_bit),
    .err_flag(err_flag), .err_src(err_src), .chk_done(chk_done), .chk_idx(chk_idx)
  );

  // {op, a, b, dst}
  localparam logic [19:0] VEC [9] = '{
    {2'b00, 8'd255, 8'd255, 2'd0},
    {2'b01, 8'd5,   8'd9,   2'd1},
    {2'b01, 8'd200, 8'd7,   2'd2},
    {2'b10, 8'd255, 8'd255, 2'd3},
    {2'b10, 8'd0,   8'd77,  2'd0},
    {2'b01, 8'd0,   8'd255, 2'd2},
    {2'b00, 8'd0,   8'd0,   2'd1},
    {2'b10, 8'd13,  8'd17,  2'd3},
    {2'b01, 8'd1,   8'd2,   2'd0}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [RES_W-1:0] model(input logic [1:0] c, input logic [7:0] a, input logic [7:0] b);
    case (c)
      2'b00:   return RES_W'(a) + RES_W'(b);
      2'b01:   return RES_W'(a) - RES_W'(b);
      default: return RES_W'(a) * RES_W'(b);
    endcase
  endfunction

  // issue one operation and read the target back (R2, R4)
  task automatic do_op(input logic [1:0] c, input logic [7:0] a, input logic [7:0] b,
                       input logic [1:0] d, input logic [RES_W-1:0] exp, input string req);
    op_valid = 1'b1; op_code = c; op_a = a; op_b = b; op_dst = d;
    @(negedge clk);
    op_valid = 1'b0; rd_sel = d;
    @(negedge clk);
    check(rd_data == exp, req, 32'(rd_data), 32'(exp));
  endtask

  task automatic wait_idx(input logic [1:0] idx, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(chk_done && chk_idx == idx) && n < 100);
    check(n < 100, "R6 checkpoint reached", 32'(n), 32'(99));
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int n;
    int prev;
    logic [1:0] pidx;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(err_flag == 1'b0, "R1 err_flag", 32'(err_flag), 0);
    check(err_src == '0, "R1 err_src", 32'(err_src), 0);
    check(chk_done == 1'b0, "R1 chk_done", 32'(chk_done), 0);
    for (int r = 0; r < NREG; r++) begin
      rd_sel = 2'(r);
      @(negedge clk);
      check(rd_data == '0, "R1 register zero", 32'(rd_data), 0);
    end

    // R6: round-robin order and spacing
    wait_idx(2'd0, n);
    pidx = 2'd0;
    for (int k = 0; k < 5; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!chk_done && n < 50);
      check(chk_idx == pidx + 2'd1, "R6 order", 32'(chk_idx), 32'(pidx + 2'd1));
      check(n == PER, "R6 spacing", 32'(n), PER);
      pidx = chk_idx;
    end

    // R2/R4/R5: vector table, each result checked then its checkpoint clean
    for (int v = 0; v < 9; v++) begin
      do_op(VEC[v][19:18], VEC[v][17:10], VEC[v][9:2], VEC[v][1:0],
            model(VEC[v][19:18], VEC[v][17:10], VEC[v][9:2]), "R2 result");
      wait_idx(VEC[v][1:0], n);
      check(err_flag == 1'b0, "R5 consistent shadow", 32'(err_flag), 0);
    end

    // R3: no-operation code leaves the register alone
    do_op(2'b00, 8'd100, 8'd23, 2'd2, 17'd123, "R2 add");
    do_op(2'b11, 8'd5, 8'd6, 2'd2, 17'd123, "R3 nop keeps value");
    wait_idx(2'd2, n);
    check(err_flag == 1'b0, "R3 no error", 32'(err_flag), 0);

    // R7: write lands just before its register's checkpoint
    wait_idx(2'd1, n);
    n = 0;
    @(negedge clk); n++;
    op_valid = 1'b1; op_code = 2'b10; op_a = 8'd7; op_b = 8'd11; op_dst = 2'd2;
    @(negedge clk); n++;
    op_valid = 1'b0;
    while (!chk_done && n < 50) begin @(negedge clk); n++; end
    check(chk_idx == 2'd2, "R7 deferred index", 32'(chk_idx), 2);
    check(n == PER + 1, "R7 deferred spacing", 32'(n), PER + 1);
    check(err_flag == 1'b0, "R7 no false error", 32'(err_flag), 0);
    rd_sel = 2'd2;
    @(negedge clk);
    check(rd_data == 17'd77, "R7 value", 32'(rd_data), 77);

    // R8/R11: flip the top bit of register 1 right after its check
    wait_idx(2'd1, n);
    inj_en = 1'b1; inj_shadow = 1'b0; inj_reg = 2'd1; inj_bit = 5'd16;
    n = 0;
    @(negedge clk); n++;
    inj_en = 1'b0;
    prev = 0;
    while (!(chk_done && chk_idx == 2'd1) && n < 100) begin
      if (chk_done && err_flag) prev++;
      @(negedge clk); n++;
    end
    check(prev == 0, "R8 not reported early", 32'(prev), 0);
    check(n == NREG * PER, "R8 detection latency", 32'(n), NREG * PER);
    check(err_flag == 1'b1, "R8 flag", 32'(err_flag), 1);
    check(err_src == 4'b0010, "R8 source", 32'(err_src), 2);

    // R10: sticky, then clear after repairing register 1
    repeat (2) @(negedge clk);
    check(err_flag == 1'b1, "R10 sticky", 32'(err_flag), 1);
    do_op(2'b00, 8'd1, 8'd1, 2'd1, 17'd2, "R2 repair");
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check(err_flag == 1'b0, "R10 clear flag", 32'(err_flag), 0);
    check(err_src == '0, "R10 clear source", 32'(err_src), 0);
    wait_idx(2'd1, n);
    check(err_flag == 1'b0, "R10 stays clear", 32'(err_flag), 0);

    // R9/R11: shadow of register 3 (residue 1) flipped to code 3
    do_op(2'b00, 8'd1, 8'd0, 2'd3, 17'd1, "R2 add one");
    wait_idx(2'd3, n);
    check(err_flag == 1'b0, "R5 before shadow fault", 32'(err_flag), 0);
    inj_en = 1'b1; inj_shadow = 1'b1; inj_reg = 2'd3; inj_bit = 5'd1;
    @(negedge clk);
    inj_en = 1'b0; inj_shadow = 1'b0;
    rd_sel = 2'd3;
    @(negedge clk);
    check(rd_data == 17'd1, "R11 main untouched by shadow flip", 32'(rd_data), 1);
    wait_idx(2'd3, n);
    check(err_flag == 1'b1, "R9 illegal shadow flag", 32'(err_flag), 1);
    check(err_src == 4'b1000, "R9 source", 32'(err_src), 8);

    // R10: detection in the same cycle as a clear wins
    wait_idx(2'd2, n);
    err_clr = 1'b1;
    @(negedge clk);
    check(err_flag == 1'b0, "R10 cleared while held", 32'(err_flag), 0);
    while (!(chk_done && chk_idx == 2'd3)) @(negedge clk);
    check(err_flag == 1'b1, "R10 detection beats clear", 32'(err_flag), 1);
    check(err_src == 4'b1000, "R10 source kept", 32'(err_src), 8);
    err_clr = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule